// File: doc/BRIEF.md
# Serial-Port Operating-State Controller

This block holds the operating state of a serial-port engine and sequences it under software control. Software requests a state by writing a small register port. The block reports the current 2-bit state together with a ready flag. The ready flag is low for a fixed settle interval after every accepted request. From the state the block derives the enables for the shift datapath and the FIFOs: flushed while in reset, running, or held with contents kept while paused.

A normal transfer walks RESET, RUN, PAUSE (where software preloads the transmit FIFO), RUN again, and finally RESET. Leaving PAUSE for RESET is guarded. It takes two consecutive clear-code writes to the state register, and a single one leaves the engine paused. A separate strobe register forces RESET at once. A configuration bit permits automatic clock gating. The gating request is modelled as one output flag.

Top module: `run_state_ctl`

## Requirements
- R1: After reset the state is RESET (code 0), ready is high, the FIFO flush enable is active and the clock-gate request is low.
- R2: The state register is at address 0. Reading it returns the state code in bits [1:0] (RESET=0, RUN=1, PAUSE=3) and ready in bit 2, with all higher bits zero. While ready is high, a write of code 0, 1 or 3 (other than 0 from PAUSE) moves the state to that code on the write's clock edge.
- R3: After every accepted state write, ready reads low for exactly SETTLE_CYCLES clock cycles and then returns high.
- R4: A state-register write made while ready is low is ignored and does not change the state.
- R5: A write of code 2 while the state is not PAUSE is ignored, and ready stays high.
- R6: In PAUSE, one write of code 2 leaves the state in PAUSE with ready high. A second write of code 2, as the very next state-register write, moves the state to RESET and starts a settle interval. Any other state-register write in between breaks the pair. A direct write of code 0 in PAUSE is ignored.
- R7: Writing 1 in bit 0 to address 1 forces RESET on the next edge with ready high, even during a settle interval, and cancels a pending first clear. Writing 0 there has no effect.
- R8: The datapath run enable is high only in RUN, the FIFO flush enable only in RESET, and the FIFO hold enable only in PAUSE.
- R9: Bit 0 of address 2 is the auto-gate permission and reads back there. The clock-gate request is high only when that bit is set and the state is not RUN.
- R10: The sequence RESET, RUN, PAUSE, RUN, RESET completes, with each step settling in SETTLE_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 state, 1 soft reset, 2 config) |
| reg_wdata | input | 2 | Write data (writable field bits) |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| state_o | output | 2 | Current state code |
| valid_o | output | 1 | Ready flag, low while a transition settles |
| dp_run_o | output | 1 | Shift datapath enable |
| fifo_flush_o | output | 1 | FIFO flush enable |
| fifo_hold_o | output | 1 | FIFO hold enable |
| clk_gate_o | output | 1 | Automatic clock-gating request |

## Verification
The bench builds the block with its defaults: a 32-bit read port, a 2-bit address and a 4-cycle settle interval. With so few states and codes, the bench sweeps every source state against every written code and computes the expected next state and settle length itself. The short settle window also keeps the clear-pair sequences, busy-time writes and soft resets landing mid-settle within a few cycles each.

// File: rtl/run_state_ctl.sv
module run_state_ctl #(
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 2,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [1:0]        reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [1:0]        state_o,
  output logic              valid_o,
  output logic              dp_run_o,
  output logic              fifo_flush_o,
  output logic              fifo_hold_o,
  output logic              clk_gate_o
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYCLES);
  localparam logic [ADDR_W-1:0] A_STATE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SWRST = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(2);
  localparam logic [1:0] ST_RESET = 2'd0;
  localparam logic [1:0] ST_RUN   = 2'd1;
  localparam logic [1:0] ST_CLEAR = 2'd2;
  localparam logic [1:0] ST_PAUSE = 2'd3;

  logic [1:0]       state_q, state_d;
  logic [CNT_W-1:0] settle_q;
  logic             armed_q, armed_d;
  logic             accept;
  logic             auto_gate_q;

  wire wr_state = reg_wr_en && (reg_addr == A_STATE);
  wire swrst    = reg_wr_en && (reg_addr == A_SWRST) && reg_wdata[0];
  wire wr_cfg   = reg_wr_en && (reg_addr == A_CFG);

  assign valid_o = (settle_q == '0);

  always_comb begin
    state_d = state_q;
    armed_d = armed_q;
    accept  = 1'b0;
    if (wr_state) begin
      armed_d = 1'b0;
      if (valid_o) begin
        if (state_q == ST_PAUSE) begin
          if (reg_wdata == ST_CLEAR) begin
            if (armed_q) begin
              state_d = ST_RESET;
              accept  = 1'b1;
            end else begin
              armed_d = 1'b1;
            end
          end else if (reg_wdata != ST_RESET) begin
            state_d = reg_wdata;
            accept  = 1'b1;
          end
        end else if (reg_wdata != ST_CLEAR) begin
          state_d = reg_wdata;
          accept  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RESET;
      settle_q <= '0;
      armed_q  <= 1'b0;
    end else if (swrst) begin
      state_q  <= ST_RESET;
      settle_q <= '0;
      armed_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      armed_q  <= armed_d;
      if (accept)
        settle_q <= SETTLE_LOAD;
      else if (settle_q != '0)
        settle_q <= settle_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      auto_gate_q <= 1'b0;
    else if (wr_cfg)
      auto_gate_q <= reg_wdata[0];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_STATE)
      reg_rdata[2:0] = {valid_o, state_q};
    else if (reg_addr == A_CFG)
      reg_rdata[0] = auto_gate_q;
  end

  assign state_o      = state_q;
  assign dp_run_o     = (state_q == ST_RUN);
  assign fifo_flush_o = (state_q == ST_RESET);
  assign fifo_hold_o  = (state_q == ST_PAUSE);
  assign clk_gate_o   = auto_gate_q && (state_q != ST_RUN);
endmodule

// File: rtl/run_state_ctl_chk.sv
module run_state_ctl_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [1:0]        reg_wdata,
  input logic [1:0]        state_o,
  input logic              valid_o,
  input logic              dp_run_o,
  input logic              fifo_flush_o,
  input logic              fifo_hold_o,
  input logic              clk_gate_o
);
  wire wr_st = reg_wr_en && (reg_addr == ADDR_W'(0));
  wire sw    = reg_wr_en && (reg_addr == ADDR_W'(1)) && reg_wdata[0];
  wire cfg0  = reg_wr_en && (reg_addr == ADDR_W'(2)) && !reg_wdata[0];

  AST_SETTLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && valid_o && reg_wdata != 2'd2 && !(reg_wdata == 2'd0 && state_o == 2'd3))
    |=> !valid_o); // R3
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && !valid_o) |=> $stable(state_o)); // R4
  AST_UNDEF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && valid_o && reg_wdata == 2'd2 && state_o != 2'd3)
    |=> ($stable(state_o) && valid_o)); // R5
  AST_PAUSE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3 && !(wr_st && reg_wdata == 2'd2) && !sw)
    |=> (state_o != 2'd0)); // R6
  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    sw |=> (state_o == 2'd0 && valid_o)); // R7
  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({dp_run_o, fifo_flush_o, fifo_hold_o}) == 1); // R8
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cfg0 |=> !clk_gate_o); // R9
  AST_RUN_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
    dp_run_o |-> !clk_gate_o); // R9
endmodule

bind run_state_ctl run_state_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .state_o(state_o), .valid_o(valid_o),
  .dp_run_o(dp_run_o), .fifo_flush_o(fifo_flush_o), .fifo_hold_o(fifo_hold_o),
  .clk_gate_o(clk_gate_o)
);

// File: tb/tb_run_state_ctl.sv
module tb_run_state_ctl;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int SETTLE = 4;

  logic clk = 0, rst_n = 0, reg_wr_en = 0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [1:0] state_o;
  logic valid_o, dp_run_o, fifo_flush_o, fifo_hold_o, clk_gate_o;
  int checks = 0, errors = 0;

  run_state_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SETTLE_CYCLES(SETTLE)) dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [1:0] d);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr_en = 0; reg_addr = '0;
  endtask

  task automatic settle(output int n);
    n = 0;
    while (!valid_o && n < 20) begin @(negedge clk); n++; end
  endtask

  task automatic go(input logic [1:0] s);
    int n;
    wr(1, 2'd1);
    if (s != 0) begin wr(0, 2'd1); settle(n); end
    if (s == 3) begin wr(0, 2'd3); settle(n); end
  endtask

  task automatic chk_en(input string req, input logic [1:0] s);
    chk(req, {dp_run_o, fifo_flush_o, fifo_hold_o},
        {s == 2'd1, s == 2'd0, s == 2'd3});
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    report();
  end

  initial begin
    int n;
    logic [1:0] st_list [3] = '{2'd0, 2'd1, 2'd3};
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 state", state_o, 0);
    chk("R1 valid", valid_o, 1);
    chk("R1 flush", fifo_flush_o, 1);
    chk("R1 gate", clk_gate_o, 0);

    // R2 R3 R5 sweep: every source state and code
    foreach (st_list[i]) begin
      for (int c = 0; c < 4; c++) begin
        logic acc;
        logic [1:0] from;
        from = st_list[i];
        acc = (c != 2) && !(from == 2'd3 && c == 0);
        go(from);
        wr(0, 2'(c));
        if (acc) begin
          chk("R2 state update", state_o, c);
          chk("R3 valid low", valid_o, 0);
          settle(n);
          chk("R3 settle length", n, SETTLE);
          chk_en("R8 enables", 2'(c));
        end else begin
          chk(c == 2 && from != 3 ? "R5 ignored state" : "R6 pause held", state_o, from);
          chk(c == 2 && from != 3 ? "R5 valid stays" : "R6 valid stays", valid_o, 1);
          chk_en("R8 enables", from);
        end
        reg_addr = 0; #1;
        chk("R2 readback", reg_rdata, {29'd0, valid_o, state_o});
      end
    end

    // R6 double clear
    go(3);
    wr(0, 2'd2);
    chk("R6 first clear", state_o, 3);
    wr(2, 2'd0);
    wr(0, 2'd2);
    chk("R6 second clear", state_o, 0);
    chk("R6 settle start", valid_o, 0);
    settle(n);
    chk("R6 settle length", n, SETTLE);

    // R6 broken pair
    go(3);
    wr(0, 2'd2);
    wr(0, 2'd3);
    settle(n);
    wr(0, 2'd2);
    chk("R6 broken pair", state_o, 3);
    wr(0, 2'd2);
    chk("R6 pair after break", state_o, 0);
    settle(n);

    // R4 busy write
    go(0);
    wr(0, 2'd1);
    wr(0, 2'd3);
    chk("R4 busy ignored", state_o, 1);
    settle(n);
    chk("R4 still run", state_o, 1);

    // R7 soft reset
    go(1);
    wr(0, 2'd3);
    wr(1, 2'd1);
    chk("R7 swrst state", state_o, 0);
    chk("R7 swrst valid", valid_o, 1);
    go(1);
    wr(1, 2'd0);
    chk("R7 bit0 zero", state_o, 1);
    go(3);
    wr(0, 2'd2);
    wr(1, 2'd1);
    wr(0, 2'd1); settle(n);
    wr(0, 2'd3); settle(n);
    wr(0, 2'd2);
    chk("R7 clear disarmed", state_o, 3);

    // R9 gating
    for (int g = 0; g < 2; g++) begin
      foreach (st_list[i]) begin
        go(st_list[i]);
        wr(2, 2'(g));
        chk("R9 gate", clk_gate_o, (g == 1) && (st_list[i] != 2'd1));
        reg_addr = 2; #1;
        chk("R9 readback", reg_rdata, g);
        reg_addr = 0;
      end
    end
    wr(2, 2'd0);

    // R10 full sequence
    wr(1, 2'd1);
    wr(0, 2'd1); settle(n); chk("R10 run", {state_o, n[3:0]}, {2'd1, 4'(SETTLE)});
    wr(0, 2'd3); settle(n); chk("R10 pause", {state_o, n[3:0]}, {2'd3, 4'(SETTLE)});
    wr(0, 2'd1); settle(n); chk("R10 run again", {state_o, n[3:0]}, {2'd1, 4'(SETTLE)});
    wr(0, 2'd0); settle(n); chk("R10 reset", {state_o, n[3:0]}, {2'd0, 4'(SETTLE)});

    report();
  end
endmodule